// File: doc/BRIEF.md
# IPv6 Extension Header Walker

The walker follows the next-header chain of one IPv6 packet. The packet arrives as a byte stream, one byte per accepted cycle, starting at the first byte of the 40-byte fixed header. It moves from the fixed header through any chain of options and routing headers. It stops at the first header that ends the chain, or at the end of the frame. For each frame it gives one verdict:

- whether the chain is well formed;
- whether the final protocol is one a later checksum stage handles (TCP, UDP or ICMPv6);
- the byte offset where the walk stopped, which is the payload start for a good chain;
- the next-header code that ended the walk.

The walker judges only the next-header and length fields of each header. It reads no byte after the header that ends the chain, so payload data that happens to look like a protocol code never changes the verdict. Several walkers can sit side by side on receive and transmit paths. Each verdict is valid for one cycle, and a checksum engine downstream latches it.

Top module: `exthdr_walker`

## Requirements
- R1: The next-header code is byte 6 of the 40-byte fixed header. It is acted on at the last fixed-header byte (offset 39). A chain with no extension headers is legal and gives payload offset 40.
- R2: Routing (code 43) and destination options (code 60) headers may repeat in any order and any number of times. In each one, byte 0 is the next-header code. Byte 1 is a length field L, and the header is (L+1)*8 bytes long, for every L from 0 to 255.
- R3: Hop-by-hop (code 0) is accepted only when the fixed header names it. When an extension header names code 0, the verdict is status 2 (misplaced hop-by-hop), with next-header 0 and offset equal to where that header would begin.
- R4: The checksum flag is 1 only when status is 0 and the final code is 6, 17 or 58. Any other final code clears it, even when later payload bytes equal those codes.
- R5: Codes 44, 51, 135, 139 and 140 are extension types this block does not walk. Reaching one gives status 1 (not recognised), with that code, the offset of that header, and the checksum flag at 0.
- R6: If the frame's last byte comes before the chain reaches a final code, the status is 3 (truncated) and the checksum flag is 0. This includes the case where the last byte closes a header whose next-header code asks for another extension header.
- R7: Each frame gives exactly one verdict. The res_valid pulse comes one cycle after the accepted byte that decides it: the last byte of the final header, or the frame's last byte when truncated.
- R8: Bytes with s_valid low are bubbles and only pause the walk. Bytes that arrive while no walk is active and without s_first produce no verdict.
- R9: While reset is low, and after it is released, res_valid is 0 until a verdict is due.
- R10: For status 0, the offset is the byte index of the first payload byte, and the next-header output is the final protocol code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | A packet byte is present |
| s_data | input | 8 | Packet byte |
| s_first | input | 1 | Byte is offset 0 of the fixed header; starts a new walk |
| s_last | input | 1 | Byte is the last byte of the frame |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_status | output | 2 | 0 good, 1 not recognised, 2 misplaced hop-by-hop, 3 truncated |
| res_csum_ok | output | 1 | Final protocol is TCP, UDP or ICMPv6 in a good chain |
| res_next_hdr | output | 8 | Next-header code that ended the walk |
| res_offset | output | OFS_W | Byte offset where the walk stopped |

## Verification
The properties assume several things about the stream:
- every frame begins with an s_first byte;
- a walk that is still open is never cut short by a new s_first;
- a frame is short enough that the offset never wraps past 2^OFS_W.

Under those assumptions, offsets of decided verdicts are 40 plus a multiple of 8. The stimulus keeps inside these limits. It builds whole frames of at most a few thousand bytes and always closes a frame with s_last before the next s_first. It inserts random bubbles between bytes. Stray bytes without s_first are sent only between frames.

// File: rtl/exthdr_pkg.sv
// Shared constants and types for the extension header walker.
// Assumes: codes follow the IPv6 next-header numbering.
package exthdr_pkg;

    localparam int FIXED_LEN = 40;
    localparam int NH_POS    = 6;
    localparam int LEN_POS   = 1;

    localparam logic [7:0] NH_HBH   = 8'd0;
    localparam logic [7:0] NH_ROUTE = 8'd43;
    localparam logic [7:0] NH_DEST  = 8'd60;
    localparam logic [7:0] NH_TCP   = 8'd6;
    localparam logic [7:0] NH_UDP   = 8'd17;
    localparam logic [7:0] NH_ICMP6 = 8'd58;

    // extension types that stop the walk as not recognised
    localparam int N_UNSUP = 5;
    localparam logic [N_UNSUP*8-1:0] UNSUP_CODES =
        {8'd140, 8'd139, 8'd135, 8'd51, 8'd44};

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_UNREC = 2'd1,
        ST_ORDER = 2'd2,
        ST_TRUNC = 2'd3
    } walk_status_e;

    typedef enum logic [2:0] {
        NC_HBH,
        NC_CHAIN,
        NC_UNSUP,
        NC_L4,
        NC_OTHER
    } nh_class_e;

endpackage

// File: rtl/exthdr_nh_class.sv
// Classifies a next-header code into the walker's decision classes.
// Assumes: pure combinational use; the code is already stable.
module exthdr_nh_class
    import exthdr_pkg::*;
(
    input  logic [7:0] code,
    output nh_class_e  cls
);

    logic [N_UNSUP-1:0] unsup_hit;

    // one comparator per unsupported extension code
    for (genvar g = 0; g < N_UNSUP; g++) begin : g_unsup
        assign unsup_hit[g] = (code == UNSUP_CODES[g*8 +: 8]);
    end

    // priority decode of the class
    always_comb begin
        if (code == NH_HBH)
            cls = NC_HBH;
        else if (code == NH_ROUTE || code == NH_DEST)
            cls = NC_CHAIN;
        else if (|unsup_hit)
            cls = NC_UNSUP;
        else if (code == NH_TCP || code == NH_UDP || code == NH_ICMP6)
            cls = NC_L4;
        else
            cls = NC_OTHER;
    end

endmodule

// File: rtl/exthdr_cursor.sv
// Tracks position inside the packet and inside the current header,
// captures each header's next-header and length fields, and flags
// the last byte of the current header.
// Assumes: fire is high only for bytes belonging to an active walk;
// descend is raised by the owner on a hdr_done byte to open a new
// extension header.
module exthdr_cursor
    import exthdr_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             first,
    input  logic [7:0]       data,
    input  logic             descend,
    output logic [OFS_W-1:0] idx,
    output logic             at_fixed,
    output logic             hdr_done,
    output logic [7:0]       nh_q
);

    localparam int HLEN_W = 8 + 3;

    logic [OFS_W-1:0]  pos_q;
    logic [HLEN_W-1:0] hpos_q;
    logic [HLEN_W-1:0] hend_q;
    logic              fixed_q;
    logic [HLEN_W-1:0] hidx;

    // current byte position, restarted by a first byte
    always_comb begin
        idx      = first ? '0 : pos_q;
        hidx     = first ? '0 : hpos_q;
        at_fixed = first | fixed_q;
    end

    // end of the current header
    always_comb begin
        if (!fire)
            hdr_done = 1'b0;
        else if (at_fixed)
            hdr_done = (hidx == HLEN_W'(FIXED_LEN - 1));
        else
            hdr_done = (hidx > HLEN_W'(LEN_POS)) && (hidx == hend_q);
    end

    // position counters and header field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            hpos_q  <= '0;
            hend_q  <= '0;
            fixed_q <= 1'b1;
            nh_q    <= '0;
        end else if (fire) begin
            pos_q <= idx + 1'b1;
            if (descend) begin
                fixed_q <= 1'b0;
                hpos_q  <= '0;
            end else begin
                fixed_q <= at_fixed;
                hpos_q  <= hidx + 1'b1;
            end
            if ((at_fixed && hidx == HLEN_W'(NH_POS)) || (!at_fixed && hidx == '0))
                nh_q <= data;
            if (!at_fixed && hidx == HLEN_W'(LEN_POS))
                hend_q <= {data, 3'b111};
        end
    end

endmodule

// File: rtl/exthdr_walker.sv
// Walks the IPv6 next-header chain of a byte stream and reports one
// verdict per frame: status, checksum eligibility, final code, offset.
// Assumes: a frame starts with s_first and ends with s_last; offsets
// fit in OFS_W bits.
module exthdr_walker
    import exthdr_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_first,
    input  logic             s_last,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic             res_csum_ok,
    output logic [7:0]       res_next_hdr,
    output logic [OFS_W-1:0] res_offset
);

    logic             active_q;
    logic             fire;
    logic [OFS_W-1:0] idx;
    logic             at_fixed;
    logic             hdr_done;
    logic [7:0]       nh_q;
    nh_class_e        cls;
    logic             cont;
    logic             stop_hdr;
    logic             trunc;
    walk_status_e     st;

    assign fire = s_valid && (s_first || active_q);

    exthdr_cursor #(.OFS_W(OFS_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .first    (s_first),
        .data     (s_data),
        .descend  (cont),
        .idx      (idx),
        .at_fixed (at_fixed),
        .hdr_done (hdr_done),
        .nh_q     (nh_q)
    );

    exthdr_nh_class u_class (
        .code (nh_q),
        .cls  (cls)
    );

    // decide at the end of each header: continue, stop or truncate
    always_comb begin
        cont = 1'b0;
        st   = ST_OK;
        if (hdr_done) begin
            case (cls)
                NC_CHAIN: cont = 1'b1;
                NC_HBH: begin
                    if (at_fixed) cont = 1'b1;
                    else          st   = ST_ORDER;
                end
                NC_UNSUP: st = ST_UNREC;
                default:  st = ST_OK;
            endcase
        end
        stop_hdr = hdr_done && !cont;
        trunc    = fire && s_last && !stop_hdr;
        if (trunc) st = ST_TRUNC;
    end

    // walk activity: opened by a first byte, closed by a verdict
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (fire)
            active_q <= !(stop_hdr || trunc);
    end

    // registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_status   <= ST_OK;
            res_csum_ok  <= 1'b0;
            res_next_hdr <= '0;
            res_offset   <= '0;
        end else begin
            res_valid <= stop_hdr || trunc;
            if (stop_hdr || trunc) begin
                res_status   <= st;
                res_csum_ok  <= (st == ST_OK) && (cls == NC_L4);
                res_next_hdr <= nh_q;
                res_offset   <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/exthdr_walker_chk.sv
// Property checker for exthdr_walker, attached by bind below.
// Assumes: frames are framed by s_first/s_last and do not wrap offsets.
module exthdr_walker_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_first,
    input logic             s_last,
    input logic             res_valid,
    input logic [1:0]       res_status,
    input logic             res_csum_ok,
    input logic [7:0]       res_next_hdr,
    input logic [OFS_W-1:0] res_offset
);

    logic got_q;

    // remembers a verdict already given for the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)                   got_q <= 1'b0;
        else if (s_valid && s_first)  got_q <= 1'b0;
        else if (res_valid)           got_q <= 1'b1;
    end

    p_csum_only_l4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_csum_ok |-> res_status == 2'd0 &&
        (res_next_hdr == 8'd6 || res_next_hdr == 8'd17 || res_next_hdr == 8'd58));

    p_order_is_hbh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd2 |-> res_next_hdr == 8'd0);

    p_unrec_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd1 |-> !res_csum_ok &&
        (res_next_hdr == 8'd44 || res_next_hdr == 8'd51 || res_next_hdr == 8'd135 ||
         res_next_hdr == 8'd139 || res_next_hdr == 8'd140));

    p_trunc_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd3 |-> $past(s_valid && s_last) && !res_csum_ok);

    p_offset_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status != 2'd3 |->
        res_offset >= OFS_W'(40) && res_offset[2:0] == 3'd0);

    p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !got_q);

    p_needs_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(s_valid));

endmodule

bind exthdr_walker exthdr_walker_chk #(.OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_valid),
    .s_first      (s_first),
    .s_last       (s_last),
    .res_valid    (res_valid),
    .res_status   (res_status),
    .res_csum_ok  (res_csum_ok),
    .res_next_hdr (res_next_hdr),
    .res_offset   (res_offset)
);

// File: tb/tb_exthdr_walker.sv
module tb_exthdr_walker;

    localparam int CLK_PERIOD = 10;
    localparam int OFS_W      = 16;
    localparam int FB_DEPTH   = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             s_valid = 1'b0;
    logic [7:0]       s_data = '0;
    logic             s_first = 1'b0;
    logic             s_last = 1'b0;
    logic             res_valid;
    logic [1:0]       res_status;
    logic             res_csum_ok;
    logic [7:0]       res_next_hdr;
    logic [OFS_W-1:0] res_offset;

    exthdr_walker #(.OFS_W(OFS_W)) dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_first(s_first), .s_last(s_last), .res_valid(res_valid),
        .res_status(res_status), .res_csum_ok(res_csum_ok),
        .res_next_hdr(res_next_hdr), .res_offset(res_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int got_cnt  = 0;
    bit finished = 1'b0;

    logic [7:0] fb [FB_DEPTH];
    int         byte_cyc [FB_DEPTH];
    int         flen;

    int         exp_status;
    int         exp_csum;
    int         exp_nh;
    int         exp_off;
    int         exp_dec;
    string      exp_tag;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    function automatic bit is_unsup(input int c);
        return c == 44 || c == 51 || c == 135 || c == 139 || c == 140;
    endfunction

    // expected verdict from the requirements, for the first n bytes of fb
    task automatic ref_walk(input int n);
        int nh;
        int pos;
        int hl;
        bit first;
        exp_csum = 0;
        exp_nh   = 0;
        exp_off  = 0;
        if (n < 40) begin
            exp_status = 3; exp_dec = n - 1; exp_tag = "R6"; return;
        end
        nh = fb[6]; pos = 40; first = 1'b1;
        for (int it = 0; it < 256; it++) begin
            if (nh == 43 || nh == 60 || (nh == 0 && first)) begin
                if (pos + 1 >= n) begin
                    exp_status = 3; exp_dec = n - 1; exp_tag = "R6"; return;
                end
                hl = (int'(fb[pos+1]) + 1) * 8;
                if (pos + hl > n) begin
                    exp_status = 3; exp_dec = n - 1; exp_tag = "R6"; return;
                end
                nh = fb[pos]; pos = pos + hl; first = 1'b0;
            end else begin
                exp_nh  = nh;
                exp_off = pos;
                exp_dec = pos - 1;
                if (nh == 0) begin
                    exp_status = 2; exp_tag = "R3";
                end else if (is_unsup(nh)) begin
                    exp_status = 1; exp_tag = "R5";
                end else begin
                    exp_status = 0;
                    exp_tag    = (pos == 40) ? "R1" : "R2";
                    exp_csum   = (nh == 6 || nh == 17 || nh == 58) ? 1 : 0;
                end
                return;
            end
        end
    endtask

    // verdict monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && res_valid && !finished) begin
            got_cnt++;
            chk(int'(res_status) == exp_status, {exp_tag, " status"}, res_status, exp_status);
            chk(int'(res_csum_ok) == exp_csum, "R4 checksum flag", res_csum_ok, exp_csum);
            chk(cyc == byte_cyc[exp_dec] + 1, "R7 verdict cycle", cyc, byte_cyc[exp_dec] + 1);
            if (exp_status != 3) begin
                chk(int'(res_next_hdr) == exp_nh, {exp_tag, " R10 next header"}, res_next_hdr, exp_nh);
                chk(int'(res_offset) == exp_off, {exp_tag, " R10 offset"}, res_offset, exp_off);
            end
        end
    end

    task automatic start_frame(input logic [7:0] nh0);
        for (int i = 0; i < 40; i++) fb[i] = 8'($urandom);
        fb[0] = 8'h60;
        fb[6] = nh0;
        flen  = 40;
    endtask

    task automatic add_ext(input logic [7:0] nxt, input int lenf);
        int hl;
        hl = (lenf + 1) * 8;
        for (int i = 0; i < hl; i++) fb[flen+i] = 8'($urandom);
        fb[flen]   = nxt;
        fb[flen+1] = 8'(lenf);
        flen = flen + hl;
    endtask

    task automatic add_payload(input int n, input bit all_six);
        for (int i = 0; i < n; i++) fb[flen+i] = all_six ? 8'd6 : 8'($urandom);
        flen = flen + n;
    endtask

    task automatic send_frame(input int n, input int bub);
        ref_walk(n);
        got_cnt = 0;
        for (int i = 0; i < n; i++) begin
            while ($urandom_range(99) < bub) begin
                s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
                s_data  = 8'($urandom);
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_data  = fb[i];
            s_first = (i == 0);
            s_last  = (i == n - 1);
            byte_cyc[i] = cyc;
            @(negedge clk);
        end
        s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
        repeat (4) @(negedge clk);
        chk(got_cnt == 1, "R7 verdicts per frame", got_cnt, 1);
    endtask

    task automatic rand_frame();
        int nx;
        int n;
        logic [7:0] codes [6];
        nx = $urandom_range(4);
        for (int j = 0; j < nx; j++) codes[j] = $urandom_range(1) ? 8'd43 : 8'd60;
        if (nx > 0 && $urandom_range(3) == 0) codes[0] = 8'd0;
        if (nx > 1 && $urandom_range(4) == 0) codes[$urandom_range(nx - 1, 1)] = 8'd0;
        case ($urandom_range(8))
            0: codes[nx] = 8'd6;
            1: codes[nx] = 8'd17;
            2: codes[nx] = 8'd58;
            3: codes[nx] = 8'd59;
            4: codes[nx] = 8'd44;
            5: codes[nx] = 8'd135;
            6: codes[nx] = 8'd1;
            default: codes[nx] = 8'($urandom);
        endcase
        start_frame(codes[0]);
        for (int j = 0; j < nx; j++) add_ext(codes[j+1], $urandom_range(3));
        add_payload($urandom_range(16), 1'b0);
        n = flen;
        if ($urandom_range(4) == 0) n = $urandom_range(flen - 1, 1);
        send_frame(n, 20);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R9 no verdict in reset", res_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(res_valid == 1'b0, "R9 no verdict after reset", res_valid, 0);

        // R1: no extension headers, TCP payload
        start_frame(8'd6); add_payload(12, 1'b0); send_frame(flen, 0);
        // R2: repeated routing and destination options, UDP
        start_frame(8'd43); add_ext(8'd60, 0); add_ext(8'd43, 2); add_ext(8'd60, 1);
        add_ext(8'd17, 0); add_payload(8, 1'b0); send_frame(flen, 10);
        // R2: maximum length field
        start_frame(8'd60); add_ext(8'd6, 255); add_payload(4, 1'b0); send_frame(flen, 0);
        // R3: hop-by-hop first is legal, then ICMPv6
        start_frame(8'd0); add_ext(8'd60, 1); add_ext(8'd58, 0); add_payload(6, 1'b0);
        send_frame(flen, 0);
        // R3: hop-by-hop in second position
        start_frame(8'd60); add_ext(8'd0, 0); add_ext(8'd6, 0); add_payload(6, 1'b0);
        send_frame(flen, 0);
        // R4: non-TCP final code with payload bytes equal to 6
        start_frame(8'd59); add_payload(20, 1'b1); send_frame(flen, 0);
        start_frame(8'd43); add_ext(8'd1, 0); add_payload(20, 1'b1); send_frame(flen, 0);
        // R5: unsupported extension type
        start_frame(8'd60); add_ext(8'd44, 0); add_payload(8, 1'b0); send_frame(flen, 0);
        // R6: frame ends inside an extension header
        start_frame(8'd43); add_ext(8'd6, 3); send_frame(flen - 5, 0);
        // R6: frame ends where another extension header is due
        start_frame(8'd43); add_ext(8'd60, 0); send_frame(flen, 0);
        // R6: one-byte frame and short fixed header
        start_frame(8'd6); send_frame(1, 0);
        start_frame(8'd6); send_frame(39, 0);
        // R10: chain ending exactly at the frame end is good
        start_frame(8'd60); add_ext(8'd17, 0); send_frame(flen, 0);

        // R8: stray bytes without a first byte give no verdict
        got_cnt = 0;
        for (int i = 0; i < 50; i++) begin
            s_valid = 1'b1; s_first = 1'b0;
            s_last  = ($urandom_range(3) == 0);
            s_data  = 8'($urandom);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_cnt == 0, "R8 stray bytes ignored", got_cnt, 0);

        for (int k = 0; k < 150; k++) rand_frame();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule